// File: doc/BRIEF.md
# Flash Write-Status Generator

This block is a synthesizable behavioural model of the status side of a parallel NOR flash. It accepts completed write commands (byte program, sector erase, chip erase, erase suspend and erase resume) and runs each embedded operation for a parameterised number of clock cycles. While an operation runs, array reads return a status byte instead of data: bit 7 is the complement of the programmed bit during a program and a constant 0 during an erase. An active-low ready/busy indication is provided as an open-drain pull-down enable.

The bus is a simplified, clock-sampled one: chip enable, write enable and output enable are active low. A write takes effect on the clock edge that first samples `we_n` high after it was low, with `ce_n` low. The command strobes tell the block which command that final write pulse completes. The unlock-sequence decoding is done outside the block. When no program is running and no erase is active, reads return bytes from a small internal array, which models the erase-suspend read mode.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle, `busy_pull_low` is 0 and every array byte reads 0xFF.
- R2: A write carrying `cmd_prog` starts a program on the clock edge that samples the write's rising `we_n`. `busy_pull_low` is then 1 for exactly PROG_CYC cycles. At completion the addressed byte becomes its old value ANDed with the written data.
- R3: During a program, any read (`ce_n` and `oe_n` low) returns bit 7 equal to the inverse of bit 7 of the data being programmed and bits 6:0 equal to 0. After completion the true stored byte is returned.
- R4: `cmd_sect_erase` erases the sector selected by the top SECT_W address bits. During the erase every read returns 0x00, so bit 7 is 0. After ERASE_CYC busy cycles every byte of that sector reads 0xFF and all other bytes are unchanged.
- R5: `cmd_chip_erase` keeps the block busy for ERASE_CYC cycles and then leaves every byte at 0xFF.
- R6: `cmd_suspend` during an erase releases `busy_pull_low` on the edge that takes the write. Reads then return array contents. The remaining erase time is frozen, so the busy cycles before the suspend plus those after the resume total ERASE_CYC.
- R7: `cmd_resume` at any address restarts a suspended erase. A resume while erasing has no effect. A suspend written after a resume is accepted again.
- R8: A program written while suspended drives `busy_pull_low` and the status of R3 for PROG_CYC cycles. The block then returns to the suspended state and reads array data until a resume.
- R9: Commands other than those named in R6 to R8 are ignored while a program or erase runs. Examples are an erase or a program during a program, and a program or another erase during an erase.
- R10: `rdata` is 0x00 whenever `ce_n` or `oe_n` is high.
- R11: A `we_n` pulse with `ce_n` high is not taken as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; its rising edge completes a write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| cmd_prog | input | 1 | Final write is a byte program |
| cmd_sect_erase | input | 1 | Final write is a sector erase |
| cmd_chip_erase | input | 1 | Final write is a chip erase |
| cmd_suspend | input | 1 | Write is an erase suspend |
| cmd_resume | input | 1 | Write is an erase resume |
| rdata | output | 8 | Read data or status byte |
| busy_pull_low | output | 1 | Open-drain enable: 1 pulls ready/busy low (busy) |

## Verification
Every state change happens on the clock edge that samples `we_n` rising, so the bench raises `we_n` one cycle after lowering it and checks `busy_pull_low` and status reads at the next falling edge. That is the first point where the new state is visible. Status reads are combinational and are sampled 1 ns after a falling edge within the same low phase. Busy durations are counted by sampling `busy_pull_low` at each rising edge, and are compared with PROG_CYC, ERASE_CYC, or their sum across a suspend, only after ready returns. Array contents are checked the cycle after completion against a model that ANDs program data and fills erased sectors with 0xFF.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              cmd_prog,
  input  logic              cmd_sect_erase,
  input  logic              cmd_chip_erase,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  output logic [7:0]        rdata,
  output logic              busy_pull_low
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam int EW = $clog2(ERASE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_SUSP, S_SPROG} st_t;

  st_t               st;
  logic              we_q;
  logic [PW-1:0]     pcnt;
  logic [EW-1:0]     ecnt;
  logic [ADDR_W-1:0] paddr;
  logic [7:0]        pdata;
  logic [SECT_W-1:0] esect;
  logic              echip;
  logic [7:0]        mem [DEPTH];

  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  wire wr_ev = !ce_n && !we_q && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      we_q  <= 1'b1;
      pcnt  <= '0;
      ecnt  <= '0;
      paddr <= '0;
      pdata <= '0;
      esect <= '0;
      echip <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      we_q <= we_n;
      case (st)
        S_IDLE:
          if (wr_ev) begin
            if (cmd_prog) begin
              st    <= S_PROG;
              paddr <= addr;
              pdata <= wdata;
              pcnt  <= PW'(PROG_CYC - 1);
            end else if (cmd_sect_erase || cmd_chip_erase) begin
              st    <= S_ERASE;
              esect <= sect_of(addr);
              echip <= cmd_chip_erase;
              ecnt  <= EW'(ERASE_CYC - 1);
            end
          end
        S_PROG, S_SPROG:
          if (pcnt == '0) begin
            mem[paddr] <= mem[paddr] & pdata;
            st <= (st == S_SPROG) ? S_SUSP : S_IDLE;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        S_ERASE:
          if (ecnt == '0) begin
            for (int i = 0; i < DEPTH; i++)
              if (echip || sect_of(ADDR_W'(i)) == esect) mem[i] <= 8'hFF;
            st <= S_IDLE;
          end else begin
            ecnt <= ecnt - 1'b1;
            if (wr_ev && cmd_suspend) st <= S_SUSP;
          end
        S_SUSP:
          if (wr_ev) begin
            if (cmd_resume) begin
              st <= S_ERASE;
            end else if (cmd_prog) begin
              st    <= S_SPROG;
              paddr <= addr;
              pdata <= wdata;
              pcnt  <= PW'(PROG_CYC - 1);
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (ce_n || oe_n)                     rdata = 8'h00;
    else if (st == S_PROG || st == S_SPROG) rdata = {~pdata[7], 7'b0};
    else if (st == S_ERASE)               rdata = 8'h00;
    else                                  rdata = mem[addr];
  end

  assign busy_pull_low = (st == S_PROG) || (st == S_ERASE) || (st == S_SPROG);

  a_r2_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull_low) |-> ($past(we_n) && !$past(ce_n) && !$past(we_n, 2)));

  a_r6_suspend_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SUSP || st == S_SPROG) && ($past(st) == S_SUSP || $past(st) == S_SPROG))
      |-> $stable(ecnt));

  a_r4_erase_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE && $past(st) == S_ERASE) |-> ecnt == EW'($past(ecnt) - 1'b1));

  a_r7_resume_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_SUSP && st == S_ERASE) |-> $past(wr_ev && cmd_resume));

  a_r8_back_to_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_pull_low) && $past(st) == S_SPROG) |-> st == S_SUSP);
endmodule

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
module test_flash_status_gen;
  localparam int AW = 4, SW = 2, PC = 3, EC = 12, N = 1 << AW;
  localparam logic [4:0] C_PROG = 5'b00001, C_SECT = 5'b00010, C_CHIP = 5'b00100,
                         C_SUSP = 5'b01000, C_RES  = 5'b10000;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [4:0] cmdv = '0;
  logic busy_pull_low;
  int checks = 0, fails = 0, busy_cnt = 0;
  logic [7:0] em [N];

  always #2.5 clk = ~clk;

  flash_status_gen #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC)) i_flash_status_gen (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .cmd_prog(cmdv[0]), .cmd_sect_erase(cmdv[1]), .cmd_chip_erase(cmdv[2]),
    .cmd_suspend(cmdv[3]), .cmd_resume(cmdv[4]), .rdata(rdata), .busy_pull_low(busy_pull_low));

  always @(posedge clk) if (rst_n && busy_pull_low) busy_cnt++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] c, logic [AW-1:0] a, logic [7:0] d, logic cen = 1'b0);
    ce_n = cen; we_n = 0; addr = a; wdata = d; cmdv = c;
    @(negedge clk) we_n = 1;
    @(negedge clk) ce_n = 1; cmdv = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    ce_n = 0; oe_n = 0; addr = a;
    #1 v = rdata;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_idle();
    while (busy_pull_low) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(string tag);
    logic [7:0] v;
    for (int a = 0; a < N; a++) begin
      rd(AW'(a), v);
      chk(tag, v, em[a]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R2: got hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, d;
    int b0, b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 ready after reset", busy_pull_low, 0);
    for (int a = 0; a < N; a++) em[a] = 8'hFF;
    chk_all("R1 array erased");
    // R10
    ce_n = 0; oe_n = 1; addr = 3; #1 chk("R10 oe_n high", rdata, 0);
    ce_n = 1; oe_n = 0; #1 chk("R10 ce_n high", rdata, 0);
    oe_n = 1;
    @(negedge clk);
    // R2 R3 sweep over all addresses
    for (int a = 0; a < N; a++) begin
      d = 8'((a * 37 + 5) ^ (a << 5));
      b0 = busy_cnt;
      wr(C_PROG, AW'(a), d);
      chk("R2 busy on write", busy_pull_low, 1);
      rd(AW'(a + 7), v);
      chk("R3 status byte", v, {~d[7], 7'b0});
      wait_idle();
      chk("R2 busy cycles", busy_cnt - b0, PC);
      em[a] &= d;
      rd(AW'(a), v);
      chk("R3 true data after", v, em[a]);
    end
    for (int a = 0; a < N; a++) begin
      d = ~8'(a * 11 + 64);
      wr(C_PROG, AW'(a), d);
      wait_idle();
      em[a] &= d;
    end
    chk_all("R2 AND merge");
    // R11
    wr(C_PROG, 0, 8'h00, 1'b1);
    chk("R11 no busy", busy_pull_low, 0);
    rd(0, v);
    chk("R11 byte unchanged", v, em[0]);
    // R4 with program during erase ignored (R9)
    b0 = busy_cnt;
    wr(C_SECT, 5, 8'h00);
    rd(1, v);
    chk("R4 erase status", v, 8'h00);
    wr(C_PROG, 12, 8'h00);
    wait_idle();
    chk("R4 busy cycles", busy_cnt - b0, EC);
    for (int a = 4; a < 8; a++) em[a] = 8'hFF;
    chk_all("R4 sector erased R9 prog ignored");
    // R9 erase during program ignored
    b0 = busy_cnt;
    wr(C_PROG, 9, 8'h0F);
    wr(C_SECT, 13, 8'h00);
    wait_idle();
    chk("R9 only program time", busy_cnt - b0, PC);
    em[9] &= 8'h0F;
    chk_all("R9 no erase");
    // R6 R7 R8
    b0 = busy_cnt;
    wr(C_SECT, 8, 8'h00);
    wr(C_SUSP, 1, 8'h00);
    chk("R6 ready on suspend", busy_pull_low, 0);
    rd(9, v);
    chk("R6 array read in suspend", v, em[9]);
    repeat (6) @(negedge clk);
    chk("R6 stays suspended", busy_pull_low, 0);
    wr(C_SUSP, 2, 8'h00);
    chk("R7 suspend in suspend ignored", busy_pull_low, 0);
    b1 = busy_cnt;
    wr(C_PROG, 2, 8'h3C);
    chk("R8 busy in suspend program", busy_pull_low, 1);
    rd(2, v);
    chk("R8 status byte", v, {~8'h3C >> 7, 7'b0});
    wait_idle();
    chk("R8 program cycles", busy_cnt - b1, PC);
    em[2] &= 8'h3C;
    rd(2, v);
    chk("R8 data after", v, em[2]);
    rd(10, v);
    chk("R8 still suspended", v, em[10]);
    wr(C_RES, 15, 8'h00);
    chk("R7 resume busy", busy_pull_low, 1);
    wr(C_RES, 3, 8'h00);
    chk("R7 resume while erasing", busy_pull_low, 1);
    wr(C_SUSP, 6, 8'h00);
    chk("R7 suspend again", busy_pull_low, 0);
    wr(C_RES, 0, 8'h00);
    wait_idle();
    chk("R6 total erase cycles", busy_cnt - b0 - PC, EC);
    for (int a = 8; a < 12; a++) em[a] = 8'hFF;
    chk_all("R7 sector erased");
    // R5
    b0 = busy_cnt;
    wr(C_CHIP, 0, 8'h00);
    rd(14, v);
    chk("R5 erase status", v, 8'h00);
    wait_idle();
    chk("R5 busy cycles", busy_cnt - b0, EC);
    for (int a = 0; a < N; a++) em[a] = 8'hFF;
    chk_all("R5 chip erased");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule